// File: doc/BRIEF.md
# Dual Cascadable Counter/Timer

This block holds two identical counter/timer channels. Each has a 16-bit counter and an 8-bit prescaler. The count clock comes from a divide-by-4 enable taken from the system clock and is divided again by the prescaler. A channel counts up or down and runs either once or continuously. In continuous mode it alternates between two reload values, so its pulse output forms a waveform with a programmable high time and low time. A synchronized rising edge on a capture pin copies the live count into a capture register. A per-channel pin can gate counting or start it.

Channel 1 can take channel 0's terminal count as its count enable. The two channels then form one 32-bit counter. Software reaches the channels through a flat register bus. Address bit 3 selects the channel and address bits 2:0 select the register. Reads are combinational from the address. Asserting `rd_en` on the status register clears that channel's sticky flags at the next clock edge. The block carries no data stream, so every pin is a plain level or pulse and there is no back-pressure.

Top module: `cnt_timer_pair`

## Requirements
- R1: After reset, every count, capture and status read returns 0, and `pulse_out` and `irq_out` are 0.
- R2: Down mode (control bit1 = 0) counts from the loaded value to 0. One tick after 0 it reloads, so each phase lasts 4*(P+1)*(R+1) clocks, where P is the prescale register (index 1) and R is the phase's reload value. Continuous mode (control bit2 = 1) uses reload A (index 2) first, then reload B (index 3), and keeps alternating.
- R3: Up mode (control bit1 = 1) counts to 16'hFFFF and then reloads. Each phase lasts 4*(P+1)*(65536-R) clocks.
- R4: `pulse_out` is 0 while the channel counts through reload A after a control write. It toggles on every terminal count.
- R5: In single mode (control bit2 = 0) the channel stops after its first terminal count. The running bit (status bit2) clears and the count holds at the terminal value.
- R6: Each terminal count raises `irq_out` for exactly one cycle and sets the sticky status bit0. A status read (index 6) with `rd_en` clears that bit.
- R7: With gate mode on (control bit3), the count changes only while the synchronized `gate_in` is high.
- R8: With trigger mode on (control bit4), an enabled channel holds its loaded count, with running = 0. It starts on the first synchronized rising edge of `trig_in`.
- R9: A synchronized rising edge on `cap_in` copies the count into the capture register (index 5) and sets status bit1. A status read clears status bit1.
- R10: When channel 1 has cascade mode on (control bit5), it advances once per channel 0 terminal count. Its prescaler is then not used.
- R11: Writing the control register (index 0) loads reload A into the count and restarts the prescaler. Control bit0 = 0 leaves the channel stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status flags) |
| addr | input | 4 | Bit 3 channel, bits 2:0 register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| cap_in | input | 2 | Capture event pins, one per channel |
| gate_in | input | 2 | Gate/trigger pins, one per channel |
| trig_in | input | 2 | Start trigger pins, one per channel |
| pulse_out | output | 2 | Pulse train outputs |
| irq_out | output | 2 | One-cycle terminal count pulses |

## Verification
The bench measures the exact clock interval between consecutive interrupts, in both directions and for both reload phases. An off-by-one in the prescaler, the divide-by-4 or the terminal test, or reload values swapped between phases, would change one of those intervals. Single mode is checked for a second interrupt, a running bit that stays set, and a count that moves past the terminal value. A gated channel is checked for drift while its gate is low. A triggered channel is checked for starting before its edge. In the cascade check, channel 1 must advance only on channel 0 terminal counts; a channel 1 that used its own prescaler would show the wrong period.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam logic [2:0] RIDX_CTRL  = 3'd0;
  localparam logic [2:0] RIDX_PRESC = 3'd1;
  localparam logic [2:0] RIDX_RLA   = 3'd2;
  localparam logic [2:0] RIDX_RLB   = 3'd3;
  localparam logic [2:0] RIDX_COUNT = 3'd4;
  localparam logic [2:0] RIDX_CAPT  = 3'd5;
  localparam logic [2:0] RIDX_STAT  = 3'd6;

  typedef struct packed {
    logic casc;
    logic trig;
    logic gate;
    logic cont;
    logic up;
    logic en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/cnt_prediv.sv
module cnt_prediv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign tick_o = (phase_q == LAST);
endmodule

// File: rtl/cnt_edge_sync.sv
module cnt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cnt_channel.sv
module cnt_channel
  import cnt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter bit CASC_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             casc_tick,
  input  logic             gate_lvl,
  input  logic             trig_rise,
  input  logic             cap_rise,
  input  logic             ctrl_we,
  input  ctl_t             ctrl_d,
  input  logic             presc_we,
  input  logic [PRE_W-1:0] presc_d,
  input  logic             rla_we,
  input  logic             rlb_we,
  input  logic [CNT_W-1:0] rl_d,
  input  logic             stat_clr,
  output ctl_t             ctrl_q,
  output logic [PRE_W-1:0] presc_q,
  output logic [CNT_W-1:0] rla_q,
  output logic [CNT_W-1:0] rlb_q,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] capt_q,
  output logic             tc_flag_q,
  output logic             cap_flag_q,
  output logic             run_q,
  output logic             pulse_q,
  output logic             irq_q,
  output logic             tick_o,
  output logic             tc_o
);
  logic             wait_q;
  logic             phase_q;
  logic [PRE_W-1:0] pre_q;
  logic             use_casc;
  logic             gate_ok;
  logic             pre_in;
  logic             pre_tick;
  logic             term;

  assign use_casc = CASC_OK && ctrl_q.casc;
  assign gate_ok  = !ctrl_q.gate || gate_lvl;
  assign pre_in   = run_q && gate_ok && base_tick && !use_casc;
  assign pre_tick = pre_in && (pre_q == '0);
  assign tick_o   = use_casc ? (run_q && gate_ok && casc_tick) : pre_tick;
  assign term     = ctrl_q.up ? (&count_q) : (count_q == '0);
  assign tc_o     = tick_o && term;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      rla_q   <= '0;
      rlb_q   <= '0;
    end else begin
      if (ctrl_we)  ctrl_q  <= ctrl_d;
      if (presc_we) presc_q <= presc_d;
      if (rla_we)   rla_q   <= rl_d;
      if (rlb_we)   rlb_q   <= rl_d;
    end
  end

  // prescaler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pre_q <= '0;
    else if (ctrl_we)              pre_q <= presc_q;
    else if (pre_in && pre_q == '0) pre_q <= presc_q;
    else if (pre_in)               pre_q <= pre_q - 1'b1;
  end

  // counter, phase, run state, pulse output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      phase_q <= 1'b0;
      pulse_q <= 1'b0;
      run_q   <= 1'b0;
      wait_q  <= 1'b0;
    end else if (ctrl_we) begin
      count_q <= rla_q;
      phase_q <= 1'b0;
      pulse_q <= 1'b0;
      run_q   <= ctrl_d.en && !ctrl_d.trig;
      wait_q  <= ctrl_d.en && ctrl_d.trig;
    end else begin
      if (wait_q && trig_rise) begin
        run_q  <= 1'b1;
        wait_q <= 1'b0;
      end
      if (tick_o) begin
        if (term) begin
          pulse_q <= ~pulse_q;
          phase_q <= ~phase_q;
          if (ctrl_q.cont) count_q <= phase_q ? rla_q : rlb_q;
          else             run_q   <= 1'b0;
        end else if (ctrl_q.up) begin
          count_q <= count_q + 1'b1;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

  // capture, flags, interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_q     <= '0;
      cap_flag_q <= 1'b0;
      tc_flag_q  <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= tc_o && !ctrl_we;
      if (cap_rise) begin
        capt_q     <= count_q;
        cap_flag_q <= 1'b1;
      end else if (stat_clr) begin
        cap_flag_q <= 1'b0;
      end
      if (tc_o && !ctrl_we) tc_flag_q <= 1'b1;
      else if (stat_clr)    tc_flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cnt_timer_pair.sv
module cnt_timer_pair
  import cnt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic [1:0]       cap_in,
  input  logic [1:0]       gate_in,
  input  logic [1:0]       trig_in,
  output logic [1:0]       pulse_out,
  output logic [1:0]       irq_out
);
  localparam int NCH = 2;
  localparam int PAD_PRE = CNT_W - PRE_W;
  localparam int PAD_CTL = CNT_W - CTL_W;
  localparam int PAD_ST  = CNT_W - 4;

  logic                      base_tick;
  logic [NCH-1:0]            gate_s, gate_r, trig_r, cap_r;
  logic [NCH-1:0]            tick_w, tc_w, run_w, tcf_w, capf_w, ctrl_we_w;
  logic [NCH-1:0]            cont_w, gate_md_w;
  logic [NCH-1:0][CNT_W-1:0] cnt_w;
  logic [NCH-1:0][CNT_W-1:0] rd_ch;

  cnt_prediv #(.DIV(DIV)) u_prediv (
    .clk(clk), .rst_n(rst_n), .tick_o(base_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic       sel;
    logic       casc_in;
    ctl_t       ctrl_q;
    logic [PRE_W-1:0] presc_q;
    logic [CNT_W-1:0] rla_q, rlb_q, capt_q;
    logic       pulse_q;

    assign sel = (addr[3] == 1'(i));
    assign ctrl_we_w[i] = wr_en && sel && addr[2:0] == RIDX_CTRL;

    if (i == 0) begin : g_first
      assign casc_in = 1'b0;
    end else begin : g_next
      assign casc_in = tc_w[i-1];
    end

    cnt_edge_sync u_gate (.clk(clk), .rst_n(rst_n), .pin_i(gate_in[i]),
                          .level_o(gate_s[i]), .rise_o(gate_r[i]));
    cnt_edge_sync u_trig (.clk(clk), .rst_n(rst_n), .pin_i(trig_in[i]),
                          .level_o(), .rise_o(trig_r[i]));
    cnt_edge_sync u_cap  (.clk(clk), .rst_n(rst_n), .pin_i(cap_in[i]),
                          .level_o(), .rise_o(cap_r[i]));

    cnt_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W), .CASC_OK(i > 0)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_tick (base_tick),
      .casc_tick (casc_in),
      .gate_lvl  (gate_s[i]),
      .trig_rise (trig_r[i]),
      .cap_rise  (cap_r[i]),
      .ctrl_we   (ctrl_we_w[i]),
      .ctrl_d    (ctl_t'(wdata[CTL_W-1:0])),
      .presc_we  (wr_en && sel && addr[2:0] == RIDX_PRESC),
      .presc_d   (wdata[PRE_W-1:0]),
      .rla_we    (wr_en && sel && addr[2:0] == RIDX_RLA),
      .rlb_we    (wr_en && sel && addr[2:0] == RIDX_RLB),
      .rl_d      (wdata),
      .stat_clr  (rd_en && sel && addr[2:0] == RIDX_STAT),
      .ctrl_q    (ctrl_q),
      .presc_q   (presc_q),
      .rla_q     (rla_q),
      .rlb_q     (rlb_q),
      .count_q   (cnt_w[i]),
      .capt_q    (capt_q),
      .tc_flag_q (tcf_w[i]),
      .cap_flag_q(capf_w[i]),
      .run_q     (run_w[i]),
      .pulse_q   (pulse_q),
      .irq_q     (irq_out[i]),
      .tick_o    (tick_w[i]),
      .tc_o      (tc_w[i])
    );

    assign pulse_out[i] = pulse_q;
    assign cont_w[i]    = ctrl_q.cont;
    assign gate_md_w[i] = ctrl_q.gate;

    always_comb begin
      unique case (addr[2:0])
        RIDX_CTRL:  rd_ch[i] = {{PAD_CTL{1'b0}}, ctrl_q};
        RIDX_PRESC: rd_ch[i] = {{PAD_PRE{1'b0}}, presc_q};
        RIDX_RLA:   rd_ch[i] = rla_q;
        RIDX_RLB:   rd_ch[i] = rlb_q;
        RIDX_COUNT: rd_ch[i] = cnt_w[i];
        RIDX_CAPT:  rd_ch[i] = capt_q;
        RIDX_STAT:  rd_ch[i] = {{PAD_ST{1'b0}}, pulse_q, run_w[i], capf_w[i], tcf_w[i]};
        default:    rd_ch[i] = '0;
      endcase
    end
  end

  assign rdata = rd_ch[addr[3]];

  logic unused_ok;
  assign unused_ok = ^gate_r;
endmodule

// File: rtl/cnt_timer_pair_chk.sv
module cnt_timer_pair_chk #(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            irq,
  input logic [1:0]            pulse,
  input logic [1:0]            tick,
  input logic [1:0]            ctrl_we,
  input logic [1:0][CNT_W-1:0] cnt,
  input logic [1:0]            run,
  input logic [1:0]            cont,
  input logic [1:0]            gate_md,
  input logic [1:0]            gate_lvl,
  input logic [1:0]            cap_rise,
  input logic [1:0]            cap_flag
);
  for (genvar i = 0; i < 2; i++) begin : g_a
    p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |=> !irq[i]);
    p_out_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> pulse[i] != $past(pulse[i]));
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick[i] && !ctrl_we[i] |=> $stable(cnt[i]));
    p_single_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] && !cont[i] && !$past(ctrl_we[i]) |-> !run[i]);
    p_gate_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gate_md[i] && !gate_lvl[i] |-> !tick[i]);
    p_cap_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_rise[i] |=> cap_flag[i]);
  end
endmodule

bind cnt_timer_pair cnt_timer_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_out), .pulse(pulse_out),
  .tick(tick_w), .ctrl_we(ctrl_we_w), .cnt(cnt_w), .run(run_w),
  .cont(cont_w), .gate_md(gate_md_w), .gate_lvl(gate_s),
  .cap_rise(cap_r), .cap_flag(capf_w)
);

// File: tb/tb_cnt_timer_pair.sv
`timescale 1ns/1ps
module tb_cnt_timer_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  cap_in = '0, gate_in = '0, trig_in = '0;
  logic [1:0]  pulse_out, irq_out;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cnt_timer_pair dut (.*);

  // control word bits: en=0 up=1 cont=2 gate=3 trig=4 casc=5
  localparam logic [15:0] C_EN = 16'h1, C_UP = 16'h2, C_CONT = 16'h4,
                          C_GATE = 16'h8, C_TRIG = 16'h10, C_CASC = 16'h20;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int idx, input logic [15:0] d);
    @(negedge clk);
    addr = {1'(ch), 3'(idx)}; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int idx, output logic [15:0] d);
    @(negedge clk);
    addr = {1'(ch), 3'(idx)}; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_irq(input int ch, output int t);
    t = -1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (irq_out[ch]) begin t = cyc; break; end
    end
  endtask

  task automatic stop_all();
    wr(0, 0, 16'h0); wr(1, 0, 16'h0);
    gate_in = '0; trig_in = '0; cap_in = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(0, 4, d); chk("R1 count0", d, 0);
    rd(1, 6, d); chk("R1 status1", d, 0);
    rd(0, 5, d); chk("R1 capture0", d, 0);
    chk("R1 pulse", pulse_out, 0);
    chk("R1 irq", irq_out, 0);
  endtask

  task automatic t_down();
    int t1, t2, t3;
    wr(0, 1, 16'd1); wr(0, 2, 16'd2); wr(0, 3, 16'd4);
    wr(0, 0, C_EN | C_CONT);
    chk("R4 pulse low in phase A", pulse_out[0], 0);
    wait_irq(0, t1);
    chk("R4 pulse high after first tc", pulse_out[0], 1);
    wait_irq(0, t2);
    chk("R4 pulse low after second tc", pulse_out[0], 0);
    wait_irq(0, t3);
    chk("R2 phase B period", t2 - t1, 40);
    chk("R2 phase A period", t3 - t2, 24);
    stop_all();
  endtask

  task automatic t_up();
    int t1, t2, t3;
    wr(1, 1, 16'd0); wr(1, 2, 16'hFFFD); wr(1, 3, 16'hFFFE);
    wr(1, 0, C_EN | C_CONT | C_UP);
    wait_irq(1, t1); wait_irq(1, t2); wait_irq(1, t3);
    chk("R3 up phase B period", t2 - t1, 8);
    chk("R3 up phase A period", t3 - t2, 12);
    stop_all();
  endtask

  task automatic t_single();
    int t1, n = 0;
    logic [15:0] d;
    wr(0, 1, 16'd0); wr(0, 2, 16'd5);
    wr(0, 0, C_EN);
    wait_irq(0, t1);
    chk("R5 first tc seen", (t1 > 0) ? 1 : 0, 1);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (irq_out[0]) n++;
    end
    chk("R5 no second tc", n, 0);
    rd(0, 4, d); chk("R5 count held at terminal", d, 0);
    rd(0, 6, d);
    chk("R5 running cleared", d[2], 0);
    chk("R6 tc flag set", d[0], 1);
    rd(0, 6, d); chk("R6 tc flag cleared by read", d[0], 0);
    stop_all();
  endtask

  task automatic t_gate();
    logic [15:0] a, b;
    wr(0, 1, 16'd0); wr(0, 2, 16'd1000);
    wr(0, 0, C_EN | C_CONT | C_GATE);
    repeat (100) @(negedge clk);
    rd(0, 4, a); chk("R7 no count while gate low", a, 1000);
    gate_in[0] = 1'b1;
    repeat (100) @(negedge clk);
    rd(0, 4, a); chk("R7 counts while gate high", (a < 1000) ? 1 : 0, 1);
    gate_in[0] = 1'b0;
    repeat (6) @(negedge clk);
    rd(0, 4, a);
    repeat (100) @(negedge clk);
    rd(0, 4, b); chk("R7 frozen after gate drop", b, a);
    stop_all();
  endtask

  task automatic t_trig();
    logic [15:0] d;
    wr(1, 1, 16'd0); wr(1, 2, 16'd1000);
    wr(1, 0, C_EN | C_CONT | C_TRIG);
    repeat (100) @(negedge clk);
    rd(1, 4, d); chk("R8 held before trigger", d, 1000);
    rd(1, 6, d); chk("R8 not running before trigger", d[2], 0);
    trig_in[1] = 1'b1; repeat (3) @(negedge clk); trig_in[1] = 1'b0;
    repeat (100) @(negedge clk);
    rd(1, 4, d); chk("R8 counting after trigger", (d < 1000) ? 1 : 0, 1);
    rd(1, 6, d); chk("R8 running after trigger", d[2], 1);
    stop_all();
  endtask

  task automatic t_capture();
    logic [15:0] d;
    wr(0, 2, 16'h1234);
    wr(0, 0, 16'h0);
    rd(0, 4, d); chk("R11 control write loads reload A", d, 16'h1234);
    cap_in[0] = 1'b1; repeat (3) @(negedge clk); cap_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    rd(0, 5, d); chk("R9 captured value", d, 16'h1234);
    rd(0, 6, d); chk("R9 capture flag set", d[1], 1);
    rd(0, 6, d); chk("R9 capture flag cleared", d[1], 0);
    stop_all();
  endtask

  task automatic t_cascade();
    int t1, t2, t3;
    wr(0, 1, 16'd0); wr(0, 2, 16'd3); wr(0, 3, 16'd3);
    wr(1, 1, 16'd200); wr(1, 2, 16'd2); wr(1, 3, 16'd2);
    wr(1, 0, C_EN | C_CONT | C_CASC);
    wr(0, 0, C_EN | C_CONT);
    wait_irq(1, t1); wait_irq(1, t2); wait_irq(1, t3);
    chk("R10 cascade period 1", t2 - t1, 48);
    chk("R10 cascade period 2", t3 - t2, 48);
    stop_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_down();
    t_up();
    t_single();
    t_gate();
    t_trig();
    t_capture();
    t_cascade();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule